// File: doc/BRIEF.md
# 8-bit ALU with Status Flags

This block is the combinational arithmetic and logic stage of a small 8-bit processor core. In one pass it takes the destination operand, a second operand (register or immediate), the stored carry, the stored zero flag and a 4-bit operation code. It returns the 8-bit result, a result write enable, a vector of status flag values and a matching vector of update strobes. The core's status register takes each flag whose strobe is set and keeps every other flag as it was.

The flag vector uses the status register's bit order. From bit 0 upward the bits are carry (bit 0), zero (1), negative (2), overflow (3), sign (4) and half-carry (5). Bits 6 and 7 belong to the global interrupt enable and the user bit, and this block never drives them. Each operation has its own set of strobes. Compare operations evaluate flags but do not write the result. The with-borrow subtract and compare can clear the zero flag coming in but can never set it, so that a comparison spread over several bytes works.

Operation codes: 0 add, 1 add with carry, 2 subtract, 3 subtract with borrow, 4 AND, 5 OR, 6 XOR, 7 one's complement, 8 negate, 9 increment, 10 decrement, 11 set all ones, 12 compare, 13 compare with borrow, 14 and 15 reserved. Unary operations act on the first operand `a_i`.

Top module: `alu8_flags`

## Requirements
- R1: Codes 0 and 1 give a_i + b_i (+ carry_i for code 1) modulo 256, with write enable 1 and update mask 0x3F. Carry is the carry out of bit 7, half-carry is the carry out of bit 3, and overflow is set when the signed sum leaves -128..127.
- R2: Codes 2 and 3 give a_i - b_i (- carry_i for code 3) modulo 256, with write enable 1 and mask 0x3F. Carry is the borrow out of bit 7, half-carry is the borrow out of bit 3, and overflow is set when the signed difference leaves -128..127.
- R3: Codes 12 and 13 produce the same result, flags and mask 0x3F as codes 2 and 3, but the write enable is 0.
- R4: For codes 3 and 13 the zero flag is 1 only when the result is zero and zero_i is 1. For every other flag-updating code, zero is 1 exactly when the result is zero.
- R5: Codes 4, 5 and 6 give a_i AND, OR or XOR b_i. Overflow is 0 and the mask is 0x1E, so carry and half-carry are not updated.
- R6: Codes 9 and 10 give a_i + 1 and a_i - 1 modulo 256 with mask 0x1E. Overflow is set only for 0x7F to 0x80 (increment) and 0x80 to 0x7F (decrement).
- R7: Code 7 gives 0xFF - a_i, with carry 1, overflow 0 and mask 0x1F.
- R8: Code 8 gives 0x00 - a_i with mask 0x3F. Carry is 1 when a_i is not 0, overflow is 1 only for a_i = 0x80, and half-carry is 1 when a_i[3:0] is not 0.
- R9: Code 11 gives 0xFF with write enable 1 and mask 0x00.
- R10: The sign flag (bit 4) equals negative XOR overflow whenever it is updated. Negative is result bit 7. A flag bit whose strobe is 0 reads 0. Mask bits 7 and 6 are always 0.
- R11: Codes 14 and 15 give result 0x00, write enable 0, mask 0x00 and flags 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 4 | Operation code |
| a_i | input | 8 | Destination operand; the only operand of unary operations |
| b_i | input | 8 | Second operand, register or immediate |
| carry_i | input | 1 | Stored carry flag |
| zero_i | input | 1 | Stored zero flag, used by the with-borrow subtract and compare |
| result_o | output | 8 | Operation result |
| wr_en_o | output | 1 | Result write enable |
| flags_o | output | 8 | New flag values in status register bit order |
| flag_upd_o | output | 8 | Update strobe for each flag bit |

## Verification
The bench targets the edges where flag logic usually goes wrong: 0x7F+1 and 0x80-1 (overflow), low-nibble boundaries (half-carry), 0x00 and 0x80 for negate, and a with-borrow subtract that yields zero while zero_i is 0. A design that sets zero instead of chaining it breaks multi-byte compares. A design that swaps carry and borrow polarity in subtract breaks unsigned branches. A design that updates carry on logic operations corrupts a carry the software meant to keep. Compares are checked for a write enable of 0, because a design that wrote them back would overwrite a register. A sweep over all codes with varied operands compares every output with an integer model built from the requirements.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  localparam int DATA_W = 8;
  localparam int SREG_W = 8;

  // flag positions inside the status vector
  localparam int FLG_C = 0;
  localparam int FLG_Z = 1;
  localparam int FLG_N = 2;
  localparam int FLG_V = 3;
  localparam int FLG_S = 4;
  localparam int FLG_H = 5;

  localparam logic [SREG_W-1:0] MASK_ARITH =
    SREG_W'((1 << FLG_C) | (1 << FLG_Z) | (1 << FLG_N) | (1 << FLG_V) | (1 << FLG_S) | (1 << FLG_H));
  localparam logic [SREG_W-1:0] MASK_LOGIC =
    SREG_W'((1 << FLG_Z) | (1 << FLG_N) | (1 << FLG_V) | (1 << FLG_S));
  localparam logic [SREG_W-1:0] MASK_CPL = MASK_LOGIC | SREG_W'(1 << FLG_C);

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_ADC  = 4'd1,
    OP_SUB  = 4'd2,
    OP_SBC  = 4'd3,
    OP_AND  = 4'd4,
    OP_OR   = 4'd5,
    OP_XOR  = 4'd6,
    OP_CPL  = 4'd7,
    OP_NEG  = 4'd8,
    OP_INC  = 4'd9,
    OP_DEC  = 4'd10,
    OP_SET  = 4'd11,
    OP_CMP  = 4'd12,
    OP_CMPC = 4'd13,
    OP_RSV0 = 4'd14,
    OP_RSV1 = 4'd15
  } alu_op_e;

  typedef struct packed {
    logic              arith;    // result from the adder path
    logic              sub;      // adder subtracts
    logic              use_cin;  // stored carry enters the adder
    logic              neg;      // operands become 0 and a
    logic              chain_z;  // zero chains with the stored zero
    logic              wr;       // result write enable
    logic [SREG_W-1:0] mask;     // flag update strobes
  } alu_ctl_t;

endpackage

// File: rtl/alu8_decode.sv
module alu8_decode
  import alu8_pkg::*;
(
  input  logic [3:0] op_i,
  output alu_ctl_t   ctl_o
);

  always_comb begin
    ctl_o = '0;
    unique case (alu_op_e'(op_i))
      OP_ADD:  begin ctl_o.arith = 1'b1; ctl_o.wr = 1'b1; ctl_o.mask = MASK_ARITH; end
      OP_ADC:  begin ctl_o.arith = 1'b1; ctl_o.use_cin = 1'b1; ctl_o.wr = 1'b1; ctl_o.mask = MASK_ARITH; end
      OP_SUB:  begin ctl_o.arith = 1'b1; ctl_o.sub = 1'b1; ctl_o.wr = 1'b1; ctl_o.mask = MASK_ARITH; end
      OP_SBC:  begin
        ctl_o.arith = 1'b1; ctl_o.sub = 1'b1; ctl_o.use_cin = 1'b1;
        ctl_o.chain_z = 1'b1; ctl_o.wr = 1'b1; ctl_o.mask = MASK_ARITH;
      end
      OP_CMP:  begin ctl_o.arith = 1'b1; ctl_o.sub = 1'b1; ctl_o.mask = MASK_ARITH; end
      OP_CMPC: begin
        ctl_o.arith = 1'b1; ctl_o.sub = 1'b1; ctl_o.use_cin = 1'b1;
        ctl_o.chain_z = 1'b1; ctl_o.mask = MASK_ARITH;
      end
      OP_NEG:  begin
        ctl_o.arith = 1'b1; ctl_o.sub = 1'b1; ctl_o.neg = 1'b1;
        ctl_o.wr = 1'b1; ctl_o.mask = MASK_ARITH;
      end
      OP_AND, OP_OR, OP_XOR, OP_INC, OP_DEC: begin
        ctl_o.wr = 1'b1; ctl_o.mask = MASK_LOGIC;
      end
      OP_CPL:  begin ctl_o.wr = 1'b1; ctl_o.mask = MASK_CPL; end
      OP_SET:  begin ctl_o.wr = 1'b1; end
      default: ctl_o = '0;
    endcase
  end

endmodule

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] x_i,
  input  logic [DW-1:0] y_i,
  input  logic          cin_i,
  input  logic          sub_i,
  output logic [DW-1:0] r_o,
  output logic          c_o,
  output logic          h_o,
  output logic          v_o
);

  localparam int HW  = DW / 2;
  localparam int MSB = DW - 1;

  logic [DW:0] full;

  always_comb begin
    if (sub_i) full = {1'b0, x_i} - {1'b0, y_i} - {{DW{1'b0}}, cin_i};
    else       full = {1'b0, x_i} + {1'b0, y_i} + {{DW{1'b0}}, cin_i};
  end

  assign r_o = full[DW-1:0];
  assign c_o = full[DW];
  // carry or borrow entering the upper half equals the three-way parity there
  assign h_o = x_i[HW] ^ y_i[HW] ^ full[HW];

  always_comb begin
    if (sub_i) v_o = (x_i[MSB] != y_i[MSB]) && (full[MSB] != x_i[MSB]);
    else       v_o = (x_i[MSB] == y_i[MSB]) && (full[MSB] != x_i[MSB]);
  end

endmodule

// File: rtl/alu8_unary.sv
module alu8_unary
  import alu8_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [3:0]    op_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  output logic [DW-1:0] r_o,
  output logic          v_o
);

  localparam logic [DW-1:0] ONE     = {{(DW-1){1'b0}}, 1'b1};
  localparam logic [DW-1:0] MIN_NEG = {1'b1, {(DW-1){1'b0}}};
  localparam logic [DW-1:0] MAX_POS = ~MIN_NEG;

  always_comb begin
    r_o = '0;
    v_o = 1'b0;
    unique case (alu_op_e'(op_i))
      OP_AND:  r_o = a_i & b_i;
      OP_OR:   r_o = a_i | b_i;
      OP_XOR:  r_o = a_i ^ b_i;
      OP_CPL:  r_o = ~a_i;
      OP_INC:  begin r_o = a_i + ONE; v_o = (a_i == MAX_POS); end
      OP_DEC:  begin r_o = a_i - ONE; v_o = (a_i == MIN_NEG); end
      OP_SET:  r_o = '1;
      default: r_o = '0;
    endcase
  end

endmodule

// File: rtl/alu8_flags.sv
module alu8_flags
  import alu8_pkg::*;
(
  input  logic [3:0]        op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              carry_i,
  input  logic              zero_i,
  output logic [DATA_W-1:0] result_o,
  output logic              wr_en_o,
  output logic [SREG_W-1:0] flags_o,
  output logic [SREG_W-1:0] flag_upd_o
);

  alu_ctl_t          ctl;
  logic [DATA_W-1:0] add_x, add_y, add_r, un_r, res;
  logic              add_c, add_h, add_v, un_v;
  logic              f_n, f_v, f_z, f_c;
  logic [SREG_W-1:0] raw;

  alu8_decode u_dec (.op_i(op_i), .ctl_o(ctl));

  assign add_x = ctl.neg ? '0 : a_i;
  assign add_y = ctl.neg ? a_i : b_i;

  alu8_addsub #(.DW(DATA_W)) u_add (
    .x_i   (add_x),
    .y_i   (add_y),
    .cin_i (ctl.use_cin & carry_i),
    .sub_i (ctl.sub),
    .r_o   (add_r),
    .c_o   (add_c),
    .h_o   (add_h),
    .v_o   (add_v)
  );

  alu8_unary #(.DW(DATA_W)) u_un (
    .op_i (op_i),
    .a_i  (a_i),
    .b_i  (b_i),
    .r_o  (un_r),
    .v_o  (un_v)
  );

  assign res = ctl.arith ? add_r : un_r;
  assign f_n = res[DATA_W-1];
  assign f_v = ctl.arith ? add_v : un_v;
  // only the complement uses the non-adder carry, and it is always 1
  assign f_c = ctl.arith ? add_c : 1'b1;
  assign f_z = (res == '0) && (!ctl.chain_z || zero_i);

  always_comb begin
    raw        = '0;
    raw[FLG_C] = f_c;
    raw[FLG_Z] = f_z;
    raw[FLG_N] = f_n;
    raw[FLG_V] = f_v;
    raw[FLG_S] = f_n ^ f_v;
    raw[FLG_H] = add_h;
  end

  assign result_o   = res;
  assign wr_en_o    = ctl.wr;
  assign flag_upd_o = ctl.mask;
  assign flags_o    = raw & ctl.mask;

endmodule

// File: rtl/alu8_flags_chk.sv
module alu8_flags_chk
  import alu8_pkg::*;
(
  input logic [3:0]        op_i,
  input logic [DATA_W-1:0] a_i,
  input logic [DATA_W-1:0] b_i,
  input logic              carry_i,
  input logic              zero_i,
  input logic [DATA_W-1:0] result_o,
  input logic              wr_en_o,
  input logic [SREG_W-1:0] flags_o,
  input logic [SREG_W-1:0] flag_upd_o
);

  always_comb begin
    if (!$isunknown({op_i, a_i, b_i, carry_i, zero_i})) begin
      assert_sign_xor_R10: assert (!flag_upd_o[FLG_S] ||
        (flags_o[FLG_S] == (flags_o[FLG_N] ^ flags_o[FLG_V])))
        else $error("sign flag not N^V");
      assert_masked_zero_R10: assert ((flags_o & ~flag_upd_o) == '0 && flag_upd_o[7:6] == 2'b00)
        else $error("flag outside its strobe");
      assert_neg_bit_R10: assert (!flag_upd_o[FLG_N] || flags_o[FLG_N] == result_o[DATA_W-1])
        else $error("negative flag differs from result msb");
      assert_zero_result_R4: assert (!flags_o[FLG_Z] || result_o == '0)
        else $error("zero flag with nonzero result");
      assert_chain_clear_R4: assert (!((op_i == OP_SBC || op_i == OP_CMPC) && !zero_i) || !flags_o[FLG_Z])
        else $error("with-borrow op set zero");
      assert_cmp_nowrite_R3: assert (!(op_i == OP_CMP || op_i == OP_CMPC) || !wr_en_o)
        else $error("compare wrote result");
      assert_cmp_equal_R3: assert (!(op_i == OP_CMP && a_i == b_i) ||
        (flags_o[FLG_Z] && !flags_o[FLG_C]))
        else $error("equal compare flags");
      assert_cmpc_equal_R4: assert (!(op_i == OP_CMPC && a_i == b_i && !carry_i && zero_i) ||
        flags_o[FLG_Z])
        else $error("chained equal compare lost zero");
      assert_logic_keep_c_R5: assert (!(op_i == OP_AND || op_i == OP_OR || op_i == OP_XOR) ||
        (!flags_o[FLG_V] && !flag_upd_o[FLG_C] && !flag_upd_o[FLG_H]))
        else $error("logic op touched V, C or H");
      assert_set_ones_R9: assert (op_i != OP_SET || (result_o == '1 && flag_upd_o == '0))
        else $error("set-all-ones wrong");
      assert_reserved_R11: assert (!(op_i == OP_RSV0 || op_i == OP_RSV1) ||
        (!wr_en_o && flag_upd_o == '0))
        else $error("reserved code had effect");
    end
  end

endmodule

bind alu8_flags alu8_flags_chk u_chk (
  .op_i       (op_i),
  .a_i        (a_i),
  .b_i        (b_i),
  .carry_i    (carry_i),
  .zero_i     (zero_i),
  .result_o   (result_o),
  .wr_en_o    (wr_en_o),
  .flags_o    (flags_o),
  .flag_upd_o (flag_upd_o)
);

// File: tb/alu8_flags_tb.sv
module alu8_flags_tb;

  logic       clk;
  logic       rst_n;
  logic [3:0] op;
  logic [7:0] a, b;
  logic       cin, zin;
  logic [7:0] res, flg, upd;
  logic       wr;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  alu8_flags u_dut (
    .op_i(op), .a_i(a), .b_i(b), .carry_i(cin), .zero_i(zin),
    .result_o(res), .wr_en_o(wr), .flags_o(flg), .flag_upd_o(upd)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic int sx(input logic [7:0] v);
    return (v > 8'd127) ? int'(v) - 256 : int'(v);
  endfunction

  // integer model written from the requirements
  task automatic model(input logic [3:0] o, input logic [7:0] x, y, input logic c, z,
                       output logic [7:0] r, output logic w, output logic [7:0] m,
                       output logic [7:0] f);
    int t, ci, sv;
    logic cf, hf, vf, nf, zf, chain;
    r = 8'h00; w = 1'b0; m = 8'h00; cf = 1'b0; hf = 1'b0; vf = 1'b0; chain = 1'b0;
    case (o)
      4'd0, 4'd1: begin
        ci = (o == 4'd1) ? int'(c) : 0;
        t = int'(x) + int'(y) + ci; r = t[7:0]; cf = (t > 255);
        hf = ((int'(x) % 16) + (int'(y) % 16) + ci) > 15;
        sv = sx(x) + sx(y) + ci; vf = (sv > 127) || (sv < -128);
        w = 1'b1; m = 8'h3F;
      end
      4'd2, 4'd3, 4'd12, 4'd13: begin
        chain = (o == 4'd3) || (o == 4'd13);
        ci = chain ? int'(c) : 0;
        t = int'(x) - int'(y) - ci; r = t[7:0]; cf = (t < 0);
        hf = ((int'(x) % 16) - (int'(y) % 16) - ci) < 0;
        sv = sx(x) - sx(y) - ci; vf = (sv > 127) || (sv < -128);
        w = (o < 4'd12); m = 8'h3F;
      end
      4'd8: begin
        t = 0 - int'(x); r = t[7:0]; cf = (x != 8'h00);
        hf = (x[3:0] != 4'h0); vf = (x == 8'h80); w = 1'b1; m = 8'h3F;
      end
      4'd4: begin r = x & y; w = 1'b1; m = 8'h1E; end
      4'd5: begin r = x | y; w = 1'b1; m = 8'h1E; end
      4'd6: begin r = x ^ y; w = 1'b1; m = 8'h1E; end
      4'd7: begin r = 8'hFF - x; cf = 1'b1; w = 1'b1; m = 8'h1F; end
      4'd9: begin r = x + 8'd1; vf = (x == 8'h7F); w = 1'b1; m = 8'h1E; end
      4'd10: begin r = x - 8'd1; vf = (x == 8'h80); w = 1'b1; m = 8'h1E; end
      4'd11: begin r = 8'hFF; w = 1'b1; end
      default: ;
    endcase
    nf = r[7];
    zf = (r == 8'h00) && (!chain || z);
    f = {2'b00, hf, nf ^ vf, vf, nf, zf, cf} & m;
  endtask

  task automatic chk8(input string tag, input string what, input logic [7:0] act, exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%02h expected=%02h", tag, what, act, exp);
    end
  endtask

  task automatic drive(input logic [3:0] o, input logic [7:0] x, y, input logic c, z);
    @(negedge clk);
    op = o; a = x; b = y; cin = c; zin = z;
    #5;
  endtask

  task automatic run(input string tag, input logic [3:0] o, input logic [7:0] x, y,
                     input logic c, z);
    logic [7:0] er, em, ef;
    logic ew;
    drive(o, x, y, c, z);
    model(o, x, y, c, z, er, ew, em, ef);
    chk8(tag, "result", res, er);
    chk8(tag, "wr_en", {7'd0, wr}, {7'd0, ew});
    chk8(tag, "mask", upd, em);
    chk8(tag, "flags", flg, ef);
  endtask

  task automatic t_reset;
    drive(4'd0, 8'h00, 8'h00, 1'b0, 1'b0);
    chk8("R1", "idle result", res, 8'h00);
    chk8("R1", "idle flags", flg, 8'h02);
  endtask

  task automatic t_add;
    drive(4'd0, 8'h7F, 8'h01, 1'b0, 1'b0);
    chk8("R1", "7F+1 flags", flg, 8'h2C);
    run("R1", 4'd0, 8'hFF, 8'h01, 1'b1, 1'b0);
    run("R1", 4'd0, 8'h80, 8'h80, 1'b0, 1'b0);
    run("R1", 4'd1, 8'h0F, 8'h00, 1'b1, 1'b0);
    run("R1", 4'd1, 8'h7F, 8'h00, 1'b1, 1'b1);
    run("R1", 4'd1, 8'hFF, 8'hFF, 1'b1, 1'b0);
  endtask

  task automatic t_sub;
    drive(4'd2, 8'h00, 8'h01, 1'b0, 1'b0);
    chk8("R2", "0-1 result", res, 8'hFF);
    chk8("R2", "0-1 flags", flg, 8'h35);
    run("R2", 4'd2, 8'h80, 8'h01, 1'b0, 1'b0);
    run("R2", 4'd2, 8'h10, 8'h01, 1'b0, 1'b0);
    run("R2", 4'd3, 8'h05, 8'h04, 1'b1, 1'b1);
    run("R2", 4'd3, 8'h00, 8'h00, 1'b1, 1'b1);
  endtask

  task automatic t_cmp;
    drive(4'd12, 8'h33, 8'h33, 1'b1, 1'b0);
    chk8("R3", "cmp equal wr", {7'd0, wr}, 8'h00);
    chk8("R3", "cmp equal flags", flg, 8'h02);
    run("R3", 4'd12, 8'h01, 8'h02, 1'b0, 1'b0);
    run("R3", 4'd13, 8'h40, 8'hC0, 1'b1, 1'b1);
  endtask

  task automatic t_chain;
    drive(4'd3, 8'h05, 8'h05, 1'b0, 1'b0);
    chk8("R4", "sbc zero held clear", flg, 8'h00);
    drive(4'd3, 8'h05, 8'h05, 1'b0, 1'b1);
    chk8("R4", "sbc zero kept", flg, 8'h02);
    drive(4'd13, 8'h06, 8'h05, 1'b1, 1'b0);
    chk8("R4", "cpc zero held clear", flg, 8'h00);
    drive(4'd13, 8'h06, 8'h05, 1'b1, 1'b1);
    chk8("R4", "cpc zero kept", flg, 8'h02);
    drive(4'd2, 8'h05, 8'h05, 1'b0, 1'b0);
    chk8("R4", "plain sub sets zero", flg, 8'h02);
  endtask

  task automatic t_logic;
    drive(4'd4, 8'hF0, 8'h0F, 1'b1, 1'b0);
    chk8("R5", "and zero", flg, 8'h02);
    chk8("R5", "and mask", upd, 8'h1E);
    run("R5", 4'd5, 8'h80, 8'h01, 1'b1, 1'b0);
    run("R5", 4'd6, 8'hAA, 8'hAA, 1'b0, 1'b1);
    run("R5", 4'd6, 8'hAA, 8'h2A, 1'b1, 1'b0);
  endtask

  task automatic t_incdec;
    drive(4'd9, 8'h7F, 8'h00, 1'b0, 1'b0);
    chk8("R6", "inc 7F result", res, 8'h80);
    chk8("R6", "inc 7F flags", flg, 8'h0C);
    drive(4'd10, 8'h80, 8'h00, 1'b0, 1'b0);
    chk8("R6", "dec 80 result", res, 8'h7F);
    chk8("R6", "dec 80 flags", flg, 8'h18);
    run("R6", 4'd9, 8'hFF, 8'h00, 1'b1, 1'b0);
    run("R6", 4'd10, 8'h00, 8'h00, 1'b0, 1'b0);
    run("R6", 4'd10, 8'h01, 8'h00, 1'b1, 1'b1);
  endtask

  task automatic t_cpl;
    drive(4'd7, 8'h5A, 8'h00, 1'b0, 1'b0);
    chk8("R7", "com result", res, 8'hA5);
    chk8("R7", "com flags", flg, 8'h15);
    chk8("R7", "com mask", upd, 8'h1F);
    run("R7", 4'd7, 8'hFF, 8'h12, 1'b0, 1'b0);
  endtask

  task automatic t_neg;
    drive(4'd8, 8'h80, 8'h00, 1'b0, 1'b0);
    chk8("R8", "neg 80 result", res, 8'h80);
    chk8("R8", "neg 80 flags", flg, 8'h0D);
    drive(4'd8, 8'h00, 8'hFF, 1'b1, 1'b0);
    chk8("R8", "neg 00 flags", flg, 8'h02);
    run("R8", 4'd8, 8'h01, 8'h00, 1'b0, 1'b0);
    run("R8", 4'd8, 8'h10, 8'h00, 1'b0, 1'b0);
  endtask

  task automatic t_set;
    drive(4'd11, 8'h12, 8'h34, 1'b1, 1'b1);
    chk8("R9", "ser result", res, 8'hFF);
    chk8("R9", "ser mask", upd, 8'h00);
    chk8("R9", "ser wr", {7'd0, wr}, 8'h01);
  endtask

  task automatic t_reserved;
    for (int k = 14; k < 16; k++) begin
      drive(4'(k), 8'hC3, 8'h3C, 1'b1, 1'b1);
      chk8("R11", "rsv result", res, 8'h00);
      chk8("R11", "rsv wr", {7'd0, wr}, 8'h00);
      chk8("R11", "rsv mask", upd, 8'h00);
      chk8("R11", "rsv flags", flg, 8'h00);
    end
  endtask

  task automatic t_sweep;
    logic [15:0] lf;
    lf = 16'hACE1;
    for (int i = 0; i < 1600; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      run("R10", 4'(i % 16), lf[7:0], lf[15:8] ^ 8'(i), lf[3], lf[9]);
    end
  endtask

  initial begin
    op = 4'd0; a = 8'h00; b = 8'h00; cin = 1'b0; zin = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_reset();
    t_add();
    t_sub();
    t_cmp();
    t_chain();
    t_logic();
    t_incdec();
    t_cpl();
    t_neg();
    t_set();
    t_reserved();
    t_sweep();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule